// File: doc/BRIEF.md
# Instruction Machine-Cycle Sequencer

This block sits one level above a bus cycle controller. For every instruction it runs a fixed series of machine cycles. An opcode fetch comes first. Zero, one or two operand reads may follow, and then an optional memory write. The block keeps the program counter and issues one request at a time: a cycle kind and an address, plus the write byte when the cycle is a write. It then waits until the controller reports completion with a single-cycle `rsp_done` pulse. A read's byte arrives on `rsp_data` in that same cycle.

Operands wider than a byte are built from two consecutive reads, low byte first. The result becomes either a register-pair load, a jump target, or the address that a later write cycle drives. An internal eight-entry register file holds the operand registers. Every write into that file is also shown on an update port, so the surrounding logic can track register state. A running T-state count grows as each machine cycle completes, which lets instruction timing be checked from outside the block.

Top module: `insn_seq`

## Requirements
- R1: While `rst_n` is low, `req_valid`, `upd_we`, `pc` and `tstate_cnt` are all zero. The first request after reset is an opcode fetch at address 0.
- R2: `req_kind` encodes the cycle kind as 2'b11 for opcode fetch, 2'b10 for memory read, 2'b01 for memory write, and 2'b00 for no request. A request keeps its kind, address and write data unchanged until the cycle in which `rsp_done` is high.
- R3: Each fetch goes to address `pc`. The program counter increments once when each fetch completes and once when each operand read completes.
- R4: A register move, opcode 2'b01,ddd,sss, uses only the fetch cycle (4 T-states) and copies register sss into register ddd. Register codes are B=0, C=1, D=2, E=3, H=4, L=5, A=7.
- R5: A move-immediate, opcode 2'b00,ddd,3'b110, adds one read (7 T-states). It loads the byte read into register ddd.
- R6: A pair load, opcode 2'b00,pp,4'b0001, adds two reads (10 T-states). Pair pp=0 is B/C, pp=1 is D/E and pp=2 is H/L. The first byte read goes to the low register (C, E or L). The second goes afterwards to the high register.
- R7: Store-accumulator, opcode 8'h32, runs a fetch, two reads and one write (13 T-states). The write address is {second byte, first byte} and the write data is register A.
- R8: Jump, opcode 8'hC3, runs a fetch and two reads (10 T-states). The next fetch is at {second byte, first byte}.
- R9: Any other opcode is a 4-T no-op with no register update. This covers the memory code 6 as operand, 8'h76, and pair code 3. Operand bytes are never decoded as opcodes.
- R10: `tstate_cnt` grows by 4 when a fetch completes and by 3 when a read or write completes. It does not change otherwise, so instruction timing does not depend on how many cycles the controller waits.
- R11: A register write appears on `upd_we`/`upd_idx`/`upd_data` as a one-cycle pulse in the cycle after the completion that supplied the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | output | 1 | A machine-cycle request is pending |
| req_kind | output | 2 | Cycle kind: fetch, read or write |
| req_addr | output | AW | Address of the requested cycle |
| req_wdata | output | DW | Byte to store in a write cycle |
| rsp_done | input | 1 | The controller completes the pending cycle |
| rsp_data | input | DW | Byte read, valid with `rsp_done` |
| upd_we | output | 1 | A register-file write took place |
| upd_idx | output | 3 | Register that was written |
| upd_data | output | DW | Value that was written |
| pc | output | AW | Program counter |
| tstate_cnt | output | TW | Running T-state total |

## Verification
The hardest case to reach is a completion arriving in the very cycle a new request first appears, directly after a register write. In that case a move reads a register in the same edge in which the previous instruction writes it. The bench's bus model can answer with zero wait, which keeps `rsp_done` high on consecutive clocks and creates exactly this collision. The same program then runs again with two wait cycles per access. An operand byte equal to the jump opcode, the unsupported codes, and a reset applied partway through a store cover the remaining corners.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [1:0] {
        CYC_NONE  = 2'b00,
        CYC_WRITE = 2'b01,
        CYC_READ  = 2'b10,
        CYC_FETCH = 2'b11
    } cyc_kind_e;

    typedef enum logic [1:0] {
        PH_FETCH,
        PH_RD_LO,
        PH_RD_HI,
        PH_WRITE
    } phase_e;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_MOV,
        OP_MVI,
        OP_LXI,
        OP_STA,
        OP_JMP
    } op_class_e;

    typedef struct packed {
        op_class_e  cls;
        logic [2:0] dst;
        logic [2:0] src;
        logic [2:0] pair_hi;
        logic [2:0] pair_lo;
    } dec_t;

    localparam logic [2:0] REG_MEM = 3'd6;
    localparam logic [2:0] REG_ACC = 3'd7;
    localparam logic [7:0] OPC_STORE_ACC = 8'h32;
    localparam logic [7:0] OPC_JUMP = 8'hC3;
    localparam logic [7:0] OPC_HALT_SLOT = 8'h76;
    localparam int T_FETCH = 4;
    localparam int T_MEMCYC = 3;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);
    logic [2:0] f_dst;
    logic [2:0] f_src;
    logic [1:0] f_pair;

    always_comb begin
        f_dst  = opcode[5:3];
        f_src  = opcode[2:0];
        f_pair = opcode[5:4];
        dec.dst     = f_dst;
        dec.src     = f_src;
        dec.pair_hi = {f_pair, 1'b0};
        dec.pair_lo = {f_pair, 1'b1};
        dec.cls     = OP_NOP;
        if (opcode == OPC_STORE_ACC) begin
            dec.cls = OP_STA;
        end else if (opcode == OPC_JUMP) begin
            dec.cls = OP_JMP;
        end else if (opcode[7:6] == 2'b01) begin
            if (opcode != OPC_HALT_SLOT && f_dst != REG_MEM && f_src != REG_MEM)
                dec.cls = OP_MOV;
        end else if (opcode[7:6] == 2'b00) begin
            if (f_src == 3'b110 && f_dst != REG_MEM)
                dec.cls = OP_MVI;
            else if (opcode[3:0] == 4'b0001 && f_pair != 2'b11)
                dec.cls = OP_LXI;
        end
    end
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 8,
    parameter int ACC  = 7,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] acc
);
    logic [DW-1:0] cells [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_cell
        logic [DW-1:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cell_q <= '0;
            else if (we && widx == IW'(g))
                cell_q <= wdata;
        end
        assign cells[g] = cell_q;
    end

    assign rdata = cells[ridx];
    assign acc   = cells[ACC];
endmodule

// File: rtl/insn_seq.sv
module insn_seq
    import seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          req_valid,
    output logic [1:0]    req_kind,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] req_wdata,
    input  logic          rsp_done,
    input  logic [DW-1:0] rsp_data,
    output logic          upd_we,
    output logic [2:0]    upd_idx,
    output logic [DW-1:0] upd_data,
    output logic [AW-1:0] pc,
    output logic [TW-1:0] tstate_cnt
);
    localparam int NREG = 8;
    localparam int OPW  = 2 * DW;

    typedef struct packed {
        logic          vld;
        phase_e        ph;
        logic [AW-1:0] pc;
        logic [DW-1:0] ir;
        logic [DW-1:0] lo;
        logic [AW-1:0] wa;
        logic [TW-1:0] tc;
        logic          uwe;
        logic [2:0]    uidx;
        logic [DW-1:0] udat;
    } st_t;

    st_t st_q, st_d;
    dec_t dec;
    logic [7:0]    op_sel;
    logic          rf_we;
    logic [2:0]    rf_widx;
    logic [DW-1:0] rf_wdata;
    logic [DW-1:0] rf_rdata;
    logic [DW-1:0] rf_acc;
    logic [OPW-1:0] joined;

    assign op_sel = 8'((st_q.ph == PH_FETCH) ? rsp_data : st_q.ir);
    assign joined = {rsp_data, st_q.lo};

    seq_decode u_dec (
        .opcode (op_sel),
        .dec    (dec)
    );

    seq_regfile #(.NREG(NREG), .DW(DW), .ACC(int'(REG_ACC))) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .widx  (rf_widx),
        .wdata (rf_wdata),
        .ridx  (dec.src),
        .rdata (rf_rdata),
        .acc   (rf_acc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b1;
        rf_we    = 1'b0;
        rf_widx  = dec.dst;
        rf_wdata = rsp_data;
        if (st_q.vld && rsp_done) begin
            unique case (st_q.ph)
                PH_FETCH: begin
                    st_d.ir = rsp_data;
                    st_d.pc = st_q.pc + 1'b1;
                    st_d.tc = st_q.tc + TW'(T_FETCH);
                    case (dec.cls)
                        OP_MOV: begin
                            rf_we    = 1'b1;
                            rf_wdata = rf_rdata;
                        end
                        OP_MVI, OP_LXI, OP_STA, OP_JMP: st_d.ph = PH_RD_LO;
                        default: st_d.ph = PH_FETCH;
                    endcase
                end
                PH_RD_LO: begin
                    st_d.pc = st_q.pc + 1'b1;
                    st_d.tc = st_q.tc + TW'(T_MEMCYC);
                    st_d.lo = rsp_data;
                    st_d.ph = PH_RD_HI;
                    case (dec.cls)
                        OP_MVI: begin
                            rf_we   = 1'b1;
                            st_d.ph = PH_FETCH;
                        end
                        OP_LXI: begin
                            rf_we   = 1'b1;
                            rf_widx = dec.pair_lo;
                        end
                        default: ;
                    endcase
                end
                PH_RD_HI: begin
                    st_d.pc = st_q.pc + 1'b1;
                    st_d.tc = st_q.tc + TW'(T_MEMCYC);
                    st_d.ph = PH_FETCH;
                    case (dec.cls)
                        OP_LXI: begin
                            rf_we   = 1'b1;
                            rf_widx = dec.pair_hi;
                        end
                        OP_STA: begin
                            st_d.wa = AW'(joined);
                            st_d.ph = PH_WRITE;
                        end
                        OP_JMP: st_d.pc = AW'(joined);
                        default: ;
                    endcase
                end
                PH_WRITE: begin
                    st_d.tc = st_q.tc + TW'(T_MEMCYC);
                    st_d.ph = PH_FETCH;
                end
                default: st_d.ph = PH_FETCH;
            endcase
        end
        st_d.uwe  = rf_we;
        st_d.uidx = rf_widx;
        st_d.udat = rf_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ph <= PH_FETCH;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        req_valid = st_q.vld;
        req_kind  = CYC_NONE;
        if (st_q.vld) begin
            unique case (st_q.ph)
                PH_FETCH:           req_kind = CYC_FETCH;
                PH_RD_LO, PH_RD_HI: req_kind = CYC_READ;
                PH_WRITE:           req_kind = CYC_WRITE;
                default:            req_kind = CYC_NONE;
            endcase
        end
        req_addr  = (st_q.ph == PH_WRITE) ? st_q.wa : st_q.pc;
        req_wdata = rf_acc;
    end

    assign upd_we     = st_q.uwe;
    assign upd_idx    = st_q.uidx;
    assign upd_data   = st_q.udat;
    assign pc         = st_q.pc;
    assign tstate_cnt = st_q.tc;
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int TW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [1:0]    req_kind,
    input logic [AW-1:0] req_addr,
    input logic [DW-1:0] req_wdata,
    input logic          rsp_done,
    input logic          upd_we,
    input logic [AW-1:0] pc,
    input logic [TW-1:0] tstate_cnt
);
    logic fin;
    assign fin = req_valid && rsp_done;

    assert_kind_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_kind != 2'b00);

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_done) |=> ($stable(req_kind) && $stable(req_addr) && $stable(req_wdata)));

    assert_fetch_tadd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && req_kind == 2'b11) |=> tstate_cnt == $past(tstate_cnt) + TW'(4));

    assert_memcyc_tadd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && (req_kind == 2'b10 || req_kind == 2'b01)) |=> tstate_cnt == $past(tstate_cnt) + TW'(3));

    assert_idle_tstable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(tstate_cnt));

    assert_fetch_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && req_kind == 2'b11) |=> pc == $past(pc) + AW'(1));

    assert_upd_follows_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        upd_we |-> $past(fin));

    assert_write_then_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && req_kind == 2'b01) |=> req_kind == 2'b11);
endmodule

bind insn_seq seq_checker #(.AW(AW), .DW(DW), .TW(TW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_done   (rsp_done),
    .upd_we     (upd_we),
    .pc         (pc),
    .tstate_cnt (tstate_cnt)
);

// File: tb/sim_insn_seq.sv
module sim_insn_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        rsp_done = 1'b0;
    logic [7:0]  rsp_data = 8'h00;
    logic        upd_we;
    logic [2:0]  upd_idx;
    logic [7:0]  upd_data;
    logic [15:0] pc;
    logic [31:0] tstate_cnt;

    always #5 clk = ~clk;

    insn_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_data(rsp_data), .upd_we(upd_we), .upd_idx(upd_idx),
        .upd_data(upd_data), .pc(pc), .tstate_cnt(tstate_cnt)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic [1:0]  nb;
        logic [7:0]  op;
        logic [7:0]  b1;
        logic [7:0]  b2;
        logic [7:0]  t;
        logic [2:0]  cyc;
        logic [1:0]  nup;
        logic [2:0]  fi;
        logic [7:0]  fd;
        logic [2:0]  li;
        logic [7:0]  ld;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VT [NV] = '{
        '{16'h0000, 2'd2, 8'h3E, 8'h5A, 8'h00, 8'd7,  3'd2, 2'd1, 3'd7, 8'h5A, 3'd7, 8'h5A, 4'd5},
        '{16'h0002, 2'd1, 8'h47, 8'h00, 8'h00, 8'd4,  3'd1, 2'd1, 3'd0, 8'h5A, 3'd0, 8'h5A, 4'd4},
        '{16'h0003, 2'd3, 8'h21, 8'h10, 8'h20, 8'd10, 3'd3, 2'd2, 3'd5, 8'h10, 3'd4, 8'h20, 4'd6},
        '{16'h0006, 2'd3, 8'h32, 8'h10, 8'h20, 8'd13, 3'd4, 2'd0, 3'd0, 8'h00, 3'd0, 8'h00, 4'd7},
        '{16'h0009, 2'd3, 8'hC3, 8'h20, 8'h00, 8'd10, 3'd3, 2'd0, 3'd0, 8'h00, 3'd0, 8'h00, 4'd8},
        '{16'h0020, 2'd1, 8'h48, 8'h00, 8'h00, 8'd4,  3'd1, 2'd1, 3'd1, 8'h5A, 3'd1, 8'h5A, 4'd4},
        '{16'h0021, 2'd1, 8'h76, 8'h00, 8'h00, 8'd4,  3'd1, 2'd0, 3'd0, 8'h00, 3'd0, 8'h00, 4'd9},
        '{16'h0022, 2'd2, 8'h1E, 8'hC3, 8'h00, 8'd7,  3'd2, 2'd1, 3'd3, 8'hC3, 3'd3, 8'hC3, 4'd9},
        '{16'h0024, 2'd3, 8'h11, 8'h34, 8'h12, 8'd10, 3'd3, 2'd2, 3'd3, 8'h34, 3'd2, 8'h12, 4'd6},
        '{16'h0027, 2'd1, 8'h7B, 8'h00, 8'h00, 8'd4,  3'd1, 2'd1, 3'd7, 8'h34, 3'd7, 8'h34, 4'd4},
        '{16'h0028, 2'd3, 8'hC3, 8'h28, 8'h00, 8'd10, 3'd3, 2'd0, 3'd0, 8'h00, 3'd0, 8'h00, 4'd8}
    };

    logic [7:0] mem [64];
    int n_chk = 0;
    int n_bad = 0;
    int wait_n = 0;
    int idx = 0;
    int ncyc = 0;
    int wr_seen = 0;
    logic [15:0] wr_a;
    logic [7:0]  wr_d;
    logic [15:0] snap_a [16];
    int snap_t [16];
    int snap_c [16];
    int nup [16];
    logic [2:0] fi [16];
    logic [7:0] fd [16];
    logic [2:0] li [16];
    logic [7:0] ld [16];

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic string rname(input logic [3:0] r);
        case (r)
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    initial begin : bus_model
        int ws;
        ws = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                rsp_done = 1'b0;
                ws = 0;
            end else begin
                if (upd_we && idx > 0 && idx < 16) begin
                    if (nup[idx] == 0) begin
                        fi[idx] = upd_idx;
                        fd[idx] = upd_data;
                    end
                    li[idx] = upd_idx;
                    ld[idx] = upd_data;
                    nup[idx]++;
                end
                rsp_done = 1'b0;
                if (req_valid) begin
                    if (ws >= wait_n) begin
                        ws = 0;
                        ncyc++;
                        if (req_kind == 2'b11) begin
                            idx++;
                            if (idx < 16) begin
                                snap_a[idx] = req_addr;
                                snap_t[idx] = int'(tstate_cnt);
                                snap_c[idx] = ncyc;
                            end
                        end
                        if (req_kind == 2'b01) begin
                            wr_seen++;
                            wr_a = req_addr;
                            wr_d = req_wdata;
                        end
                        rsp_data = mem[req_addr[5:0]];
                        rsp_done = 1'b1;
                    end else begin
                        ws++;
                    end
                end
            end
        end
    end

    task automatic start_run(input int w);
        @(negedge clk);
        rst_n = 1'b0;
        wait_n = w;
        idx = 0;
        ncyc = 0;
        wr_seen = 0;
        for (int i = 0; i < 16; i++) begin
            nup[i] = 0;
            snap_t[i] = 0;
            snap_c[i] = 0;
            snap_a[i] = '0;
        end
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
        for (int k = 0; k < NV; k++) begin
            mem[VT[k].addr[5:0]] = VT[k].op;
            if (VT[k].nb > 1) mem[VT[k].addr[5:0] + 6'd1] = VT[k].b1;
            if (VT[k].nb > 2) mem[VT[k].addr[5:0] + 6'd2] = VT[k].b2;
        end
        repeat (2) @(negedge clk);
        chk(req_valid == 1'b0 && upd_we == 1'b0, "R1", "idle in reset", int'(req_valid), 0);
        chk(pc == 16'h0 && tstate_cnt == 32'h0, "R1", "pc/tcount in reset", int'(pc) + int'(tstate_cnt), 0);
        #2 rst_n = 1'b1;
    endtask

    task automatic run_program(input int w);
        start_run(w);
        while (idx < NV + 1) @(negedge clk);
        #1;
        chk(snap_t[1] == 0, "R1", "tcount at first fetch", snap_t[1], 0);
        for (int k = 0; k < NV; k++) begin
            chk(snap_a[k+1] == VT[k].addr, "R3", $sformatf("fetch addr #%0d", k), int'(snap_a[k+1]), int'(VT[k].addr));
            chk(snap_t[k+2] - snap_t[k+1] == int'(VT[k].t), "R10", $sformatf("T-states #%0d", k),
                snap_t[k+2] - snap_t[k+1], int'(VT[k].t));
            chk(snap_c[k+2] - snap_c[k+1] == int'(VT[k].cyc), rname(VT[k].req), $sformatf("cycles #%0d", k),
                snap_c[k+2] - snap_c[k+1], int'(VT[k].cyc));
            chk(nup[k+1] == int'(VT[k].nup), "R11", $sformatf("update count #%0d", k), nup[k+1], int'(VT[k].nup));
            if (VT[k].nup != 0) begin
                chk(fi[k+1] == VT[k].fi && fd[k+1] == VT[k].fd, rname(VT[k].req), $sformatf("first update #%0d", k),
                    int'({fi[k+1], fd[k+1]}), int'({VT[k].fi, VT[k].fd}));
                chk(li[k+1] == VT[k].li && ld[k+1] == VT[k].ld, rname(VT[k].req), $sformatf("last update #%0d", k),
                    int'({li[k+1], ld[k+1]}), int'({VT[k].li, VT[k].ld}));
            end
        end
        chk(wr_seen == 1, "R7", "write count", wr_seen, 1);
        chk(wr_a == 16'h2010, "R7", "write address", int'(wr_a), 16'h2010);
        chk(wr_d == 8'h5A, "R7", "write data", int'(wr_d), 8'h5A);
        chk(snap_a[NV+1] == 16'h0028, "R8", "jump target refetch", int'(snap_a[NV+1]), 16'h0028);
    endtask

    initial begin : main
        run_program(0);
        run_program(2);
        start_run(1);
        while (idx < 4 || ncyc < 6) @(negedge clk);
        #1 rst_n = 1'b0;
        #1;
        chk(pc == 16'h0 && tstate_cnt == 32'h0, "R1", "reset mid store", int'(pc) + int'(tstate_cnt), 0);
        chk(req_valid == 1'b0, "R1", "no request mid-store reset", int'(req_valid), 0);
        @(negedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(req_valid && req_kind == 2'b11 && req_addr == 16'h0, "R2", "first request after reset",
            int'({req_kind, req_addr}), int'({2'b11, 16'h0}));
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", idx, NV + 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule